// File: doc/BRIEF.md
# Micro-op loop streamer

The block sits beside a circular queue of decoded micro-operations and watches each operation written into it. Every operation arrives with its code address and five tags: whether it is a taken branch (with the branch's target address), whether it is a call or return, whether it pushes or pops the stack, which 32-byte code chunk it came from, and whether it is also held in the decoded-operation cache. When a taken branch jumps back to an operation still held in the queue, the operations from that target up to the branch form a candidate loop body.

A candidate is checked against fixed limits: its size, the number of taken branches in it, the number of code chunks it covers, cache residency, the absence of calls and returns, and a balanced stack. A body that passes is replayed straight from the queue, up to four operations per cycle, over and over. While this goes on a sleep output lets the fetch and decode front end be gated off. A branch mispredict ends replay. A flush wipes the queue and all detection state.

Top module: `uop_loop_streamer`

## Requirements
- R1: After reset or a cycle with `flush` high, `loop_active`, `fe_sleep` and every `rep_valid` lane are 0. A flush marks every queue entry empty, so a taken branch that targets an address written before the flush does not start replay.
- R2: Replay can start only from an operation accepted with `in_valid`=1 and `in_taken`=1 while `loop_active`=0 whose `in_target` equals the address of a held, non-empty entry (the branch itself included). The body runs from the youngest such entry through the branch. `loop_active` rises after the second rising clock edge that follows the cycle in which the branch was accepted. It then stays high until a mispredict or a flush.
- R3: A body of more than MAX_OPS (28) operations is rejected; a body of exactly 28 is accepted.
- R4: A body with more than MAX_TAKEN (8) operations carrying `in_taken`=1 is rejected. The closing branch counts toward the limit.
- R5: The chunk count of a body is 1 plus the number of neighbouring body operations whose `in_chunk` values differ. A body whose chunk count is above MAX_CHUNKS (8) is rejected.
- R6: A body containing any operation with `in_cached`=0 is rejected.
- R7: A body containing any operation with `in_callret`=1 is rejected.
- R8: A body whose count of `in_push`=1 operations differs from its count of `in_pop`=1 operations is rejected.
- R9: During replay, lane j of `rep_addr` (bits j*16 upward) carries the address of body operation number off+j, and `rep_valid` is set for lanes 0 upward while off+j is below the body length. The offset off starts at 0. After each cycle off advances by 4, or returns to 0 once off+4 reaches the body length.
- R10: `fe_sleep` is high exactly while `loop_active` is high and `mispredict` is low. In a cycle with `mispredict` high, `fe_sleep` and all `rep_valid` lanes are 0, and `loop_active` is 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears the queue, any pending candidate and replay |
| in_valid | input | 1 | An operation is written into the queue this cycle (ignored while replaying) |
| in_addr | input | 16 | Code address of the operation |
| in_target | input | 16 | Branch target address, meaningful when in_taken is 1 |
| in_taken | input | 1 | Operation is a taken branch |
| in_callret | input | 1 | Operation is a call or return |
| in_push | input | 1 | Operation pushes the stack |
| in_pop | input | 1 | Operation pops the stack |
| in_chunk | input | 8 | Identifier of the 32-byte code chunk |
| in_cached | input | 1 | Operation is resident in the decoded-operation cache |
| mispredict | input | 1 | Branch mispredict: ends replay |
| rep_valid | output | 4 | Per-lane replay valid |
| rep_addr | output | 64 | Per-lane replayed operation address, 16 bits per lane |
| fe_sleep | output | 1 | Front end may sleep |
| loop_active | output | 1 | A qualified loop is being replayed |

## Verification
A wrong loop start or length would show on the very first replay cycle: lane 0 would carry the wrong address, or the lane count would differ in the cycle that reaches the loop end. A wrong offset update would garble the stream within one or two cycles. Each qualification limit is driven on both sides of its boundary. A counting error would then show as `loop_active` rising, or failing to rise, two edges after the closing branch. Leftover state after a flush or mispredict shows up as replay starting from stale entries, or as sleep outlasting the mispredict cycle.

// File: rtl/uls_pkg.sv
package uls_pkg;

    localparam int LSD_AW = 16;
    localparam int LSD_CW = 8;

    typedef struct packed {
        logic              valid;
        logic [LSD_AW-1:0] addr;
        logic              taken;
        logic              callret;
        logic              push;
        logic              pop;
        logic [LSD_CW-1:0] chunk;
        logic              cached;
    } lsd_uop_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPLAY = 1'b1
    } uls_state_e;

endpackage

// File: rtl/uls_ring.sv
module uls_ring
    import uls_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  lsd_uop_t      wr_uop,
    output logic [IW-1:0] wr_ptr,
    output lsd_uop_t      entries [DEPTH]
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                entries[i].valid <= 1'b0;
            end
        end else if (wr_en) begin
            entries[wr_ptr] <= wr_uop;
            wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/uls_qualify.sv
module uls_qualify
    import uls_pkg::*;
#(
    parameter  int DEPTH      = 32,
    parameter  int MAX_OPS    = 28,
    parameter  int MAX_TAKEN  = 8,
    parameter  int MAX_CHUNKS = 8,
    localparam int IW         = $clog2(DEPTH)
) (
    input  lsd_uop_t          entries [DEPTH],
    input  logic [IW-1:0]     end_idx,
    input  logic [LSD_AW-1:0] target,
    output logic [IW-1:0]     start_idx,
    output logic [IW:0]       body_len,
    output logic              qualified
);

    always_comb begin
        logic [IW-1:0] idx;
        logic [IW-1:0] prv;
        logic [IW-1:0] m;
        logic          found;
        logic          bad;
        int            len;
        int            n_taken;
        int            n_push;
        int            n_pop;
        int            n_chunk;

        found   = 1'b0;
        bad     = 1'b0;
        m       = '0;
        len     = 0;
        n_taken = 0;
        n_push  = 0;
        n_pop   = 0;
        n_chunk = 1;

        // youngest match wins: smallest distance back from the branch is written last
        for (int d = DEPTH - 1; d >= 0; d--) begin
            idx = IW'((int'(end_idx) + DEPTH - d) % DEPTH);
            if (entries[idx].valid && entries[idx].addr == target) begin
                found = 1'b1;
                m     = idx;
                len   = d + 1;
            end
        end

        for (int k = 0; k < DEPTH; k++) begin
            idx = IW'((int'(m) + k) % DEPTH);
            prv = IW'((int'(m) + k + DEPTH - 1) % DEPTH);
            if (k < len) begin
                if (entries[idx].taken) n_taken++;
                if (entries[idx].push)  n_push++;
                if (entries[idx].pop)   n_pop++;
                if (!entries[idx].cached || entries[idx].callret) bad = 1'b1;
                if (k > 0 && entries[idx].chunk != entries[prv].chunk) n_chunk++;
            end
        end

        start_idx = m;
        body_len  = (IW+1)'(len);
        qualified = found && !bad && (len <= MAX_OPS) && (n_taken <= MAX_TAKEN)
                    && (n_chunk <= MAX_CHUNKS) && (n_push == n_pop);
    end

endmodule

// File: rtl/uls_replay.sv
module uls_replay
    import uls_pkg::*;
#(
    parameter  int DEPTH = 32,
    parameter  int LANES = 4,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     mispredict,
    input  logic                     go,
    input  logic [IW-1:0]            go_start,
    input  logic [IW:0]              go_len,
    input  logic [LSD_AW-1:0]        addrs [DEPTH],
    output logic                     active,
    output logic                     fe_sleep,
    output logic [LANES-1:0]         lane_v,
    output logic [LANES*LSD_AW-1:0]  lane_addr
);

    uls_state_e    st;
    logic [IW-1:0] start;
    logic [IW:0]   len;
    logic [IW:0]   off;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st    <= ST_IDLE;
            start <= '0;
            len   <= '0;
            off   <= '0;
        end else if (mispredict) begin
            st <= ST_IDLE;
        end else if (st == ST_IDLE) begin
            if (go) begin
                st    <= ST_REPLAY;
                start <= go_start;
                len   <= go_len;
                off   <= '0;
            end
        end else begin
            off <= (int'(off) + LANES >= int'(len)) ? '0 : off + (IW+1)'(LANES);
        end
    end

    assign active   = (st == ST_REPLAY);
    assign fe_sleep = active && !mispredict;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_v[j] = fe_sleep && ((int'(off) + j) < int'(len));
        assign lane_addr[j*LSD_AW +: LSD_AW] =
            addrs[IW'((int'(start) + int'(off) + j) % DEPTH)];
    end

endmodule

// File: rtl/uop_loop_streamer.sv
module uop_loop_streamer
    import uls_pkg::*;
#(
    parameter  int DEPTH      = 32,
    parameter  int LANES      = 4,
    parameter  int MAX_OPS    = 28,
    parameter  int MAX_TAKEN  = 8,
    parameter  int MAX_CHUNKS = 8,
    localparam int IW         = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     in_valid,
    input  logic [LSD_AW-1:0]        in_addr,
    input  logic [LSD_AW-1:0]        in_target,
    input  logic                     in_taken,
    input  logic                     in_callret,
    input  logic                     in_push,
    input  logic                     in_pop,
    input  logic [LSD_CW-1:0]        in_chunk,
    input  logic                     in_cached,
    input  logic                     mispredict,
    output logic [LANES-1:0]         rep_valid,
    output logic [LANES*LSD_AW-1:0]  rep_addr,
    output logic                     fe_sleep,
    output logic                     loop_active
);

    lsd_uop_t          new_uop;
    lsd_uop_t          entries [DEPTH];
    logic [LSD_AW-1:0] addrs   [DEPTH];
    logic [IW-1:0]     wp;
    logic              accept;

    logic              pend_v;
    logic [LSD_AW-1:0] pend_tgt;
    logic [IW-1:0]     pend_end;

    logic [IW-1:0]     q_start;
    logic [IW:0]       q_len;
    logic              q_ok;

    assign accept  = in_valid && !loop_active;
    assign new_uop = '{valid: 1'b1, addr: in_addr, taken: in_taken, callret: in_callret,
                       push: in_push, pop: in_pop, chunk: in_chunk, cached: in_cached};

    uls_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (accept),
        .wr_uop  (new_uop),
        .wr_ptr  (wp),
        .entries (entries)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) addrs[i] = entries[i].addr;
    end

    // candidate is evaluated one cycle after its closing branch is stored
    always_ff @(posedge clk) begin
        if (rst || flush || mispredict) begin
            pend_v   <= 1'b0;
            pend_tgt <= '0;
            pend_end <= '0;
        end else begin
            pend_v <= accept && in_taken;
            if (accept && in_taken) begin
                pend_tgt <= in_target;
                pend_end <= wp;
            end
        end
    end

    uls_qualify #(
        .DEPTH      (DEPTH),
        .MAX_OPS    (MAX_OPS),
        .MAX_TAKEN  (MAX_TAKEN),
        .MAX_CHUNKS (MAX_CHUNKS)
    ) u_qualify (
        .entries   (entries),
        .end_idx   (pend_end),
        .target    (pend_tgt),
        .start_idx (q_start),
        .body_len  (q_len),
        .qualified (q_ok)
    );

    uls_replay #(.DEPTH(DEPTH), .LANES(LANES)) u_replay (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .mispredict (mispredict),
        .go         (pend_v && q_ok),
        .go_start   (q_start),
        .go_len     (q_len),
        .addrs      (addrs),
        .active     (loop_active),
        .fe_sleep   (fe_sleep),
        .lane_v     (rep_valid),
        .lane_addr  (rep_addr)
    );

endmodule

// File: rtl/uls_checker.sv
module uls_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             in_valid,
    input logic             in_taken,
    input logic             mispredict,
    input logic [LANES-1:0] rep_valid,
    input logic             fe_sleep,
    input logic             loop_active
);

    p_flush_idle_r1: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!loop_active && !fe_sleep && rep_valid == '0));

    p_rise_branch_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(loop_active) |-> $past(in_valid && in_taken, 2));

    p_hold_active_r2: assert property (@(posedge clk) disable iff (rst)
        (loop_active && !mispredict && !flush) |=> loop_active);

    p_lane_zero_r9: assert property (@(posedge clk) disable iff (rst)
        fe_sleep |-> rep_valid[0]);

    p_lane_contig_r9: assert property (@(posedge clk) disable iff (rst)
        (rep_valid & (rep_valid + LANES'(1))) == '0);

    p_mispredict_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (loop_active && mispredict) |=> !loop_active);

endmodule

bind uop_loop_streamer uls_checker #(.LANES(LANES)) u_uls_checker (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .in_valid    (in_valid),
    .in_taken    (in_taken),
    .mispredict  (mispredict),
    .rep_valid   (rep_valid),
    .fe_sleep    (fe_sleep),
    .loop_active (loop_active)
);

// File: tb/uop_loop_streamer_bench.sv
`timescale 1ns/1ps
module uop_loop_streamer_bench;

    localparam int RCYC = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_addr = '0;
    logic [15:0] in_target = '0;
    logic        in_taken = 1'b0;
    logic        in_callret = 1'b0;
    logic        in_push = 1'b0;
    logic        in_pop = 1'b0;
    logic [7:0]  in_chunk = '0;
    logic        in_cached = 1'b0;
    logic        mispredict = 1'b0;
    logic [3:0]  rep_valid;
    logic [63:0] rep_addr;
    logic        fe_sleep;
    logic        loop_active;

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    int body[32];
    int blen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uop_loop_streamer u_uop_loop_streamer (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_addr(in_addr),
        .in_target(in_target), .in_taken(in_taken), .in_callret(in_callret),
        .in_push(in_push), .in_pop(in_pop), .in_chunk(in_chunk), .in_cached(in_cached),
        .mispredict(mispredict), .rep_valid(rep_valid), .rep_addr(rep_addr),
        .fe_sleep(fe_sleep), .loop_active(loop_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: pops the scoreboard for every valid replay lane (R9)
    always @(negedge clk) begin
        #5;
        for (int j = 0; j < 4; j++) begin
            if (rep_valid[j]) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected lane", int'(rep_addr[j*16 +: 16]), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(rep_addr[j*16 +: 16]) == e, "R9 lane address",
                          int'(rep_addr[j*16 +: 16]), e);
                end
            end
        end
    end

    task automatic enq(input int a, input bit tk, input int tg, input bit cr,
                       input bit pu, input bit po, input int ch, input bit ca);
        in_valid = 1'b1; in_addr = 16'(a); in_taken = tk; in_target = 16'(tg);
        in_callret = cr; in_push = pu; in_pop = po; in_chunk = 8'(ch); in_cached = ca;
        @(negedge clk);
        in_valid = 1'b0; in_taken = 1'b0; in_callret = 1'b0; in_push = 1'b0; in_pop = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic make_loop(input int base, input int len, input int inner_taken,
                             input int chunk_step, input int bad_cache, input int cr_idx,
                             input int pushes, input int pops);
        do_flush();
        blen = len;
        for (int k = 0; k < len; k++) begin
            bit last;
            last = (k == len - 1);
            body[k] = base + k;
            enq(base + k, last || (k < inner_taken), last ? base : 'hFFFF, k == cr_idx,
                k < pushes, (k >= pushes) && (k < pushes + pops), chunk_step * k,
                k != bad_cache);
        end
    endtask

    task automatic expect_replay(input string req);
        int off;
        off = 0;
        for (int c = 0; c < RCYC; c++) begin
            for (int j = 0; j < 4 && off + j < blen; j++) exp_q.push_back(body[off + j]);
            off = (off + 4 >= blen) ? 0 : off + 4;
        end
        @(negedge clk); #1;
        check(loop_active == 1'b1, req, int'(loop_active), 1);
        repeat (RCYC) @(negedge clk);
        mispredict = 1'b1; #1;
        check(fe_sleep == 1'b0 && rep_valid == 4'b0, "R10 quiet on mispredict",
              int'({fe_sleep, rep_valid}), 0);
        check(loop_active == 1'b1, "R10 active during mispredict cycle", int'(loop_active), 1);
        @(negedge clk);
        mispredict = 1'b0; #1;
        check(loop_active == 1'b0, "R10 exit after mispredict", int'(loop_active), 0);
        check(exp_q.size() == 0, {req, " stream drained"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic expect_reject(input string req);
        @(negedge clk); #1;
        check(loop_active == 1'b0, req, int'(loop_active), 0);
        repeat (2) @(negedge clk); #1;
        check(loop_active == 1'b0 && fe_sleep == 1'b0, req, int'({loop_active, fe_sleep}), 0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(loop_active == 0 && fe_sleep == 0 && rep_valid == 0, "R1 reset state",
              int'({loop_active, fe_sleep, rep_valid}), 0);

        // R2 / R9 / R10: six-op loop, clean
        make_loop('h100, 6, 0, 0, -1, -1, 0, 0);
        expect_replay("R2 loop of 6");

        // R9: single-op loop and five-op loop (partial final cycle)
        make_loop('h140, 1, 0, 0, -1, -1, 0, 0);
        expect_replay("R9 loop of 1");
        make_loop('h150, 5, 0, 0, -1, -1, 0, 0);
        expect_replay("R9 loop of 5");

        // R3: size boundary
        make_loop('h200, 28, 0, 0, -1, -1, 0, 0);
        expect_replay("R3 size 28 accepted");
        make_loop('h240, 29, 0, 0, -1, -1, 0, 0);
        expect_reject("R3 size 29 rejected");

        // R4: taken-branch boundary
        make_loop('h300, 10, 7, 0, -1, -1, 0, 0);
        expect_replay("R4 eight taken accepted");
        make_loop('h320, 10, 8, 0, -1, -1, 0, 0);
        expect_reject("R4 nine taken rejected");

        // R5: chunk boundary
        make_loop('h400, 8, 0, 1, -1, -1, 0, 0);
        expect_replay("R5 eight chunks accepted");
        make_loop('h420, 9, 0, 1, -1, -1, 0, 0);
        expect_reject("R5 nine chunks rejected");

        // R6: uncached op
        make_loop('h500, 6, 0, 0, 2, -1, 0, 0);
        expect_reject("R6 uncached rejected");

        // R7: call/return op
        make_loop('h520, 6, 0, 0, -1, 3, 0, 0);
        expect_reject("R7 call/return rejected");

        // R8: stack balance
        make_loop('h600, 6, 0, 0, -1, -1, 2, 2);
        expect_replay("R8 balanced accepted");
        make_loop('h620, 6, 0, 0, -1, -1, 2, 1);
        expect_reject("R8 unbalanced rejected");

        // R2: youngest matching entry defines the start
        do_flush();
        enq('h700, 0, 0, 0, 0, 0, 0, 1);
        enq('h701, 0, 0, 0, 0, 0, 0, 1);
        enq('h700, 0, 0, 0, 0, 0, 0, 1);
        enq('h702, 1, 'h700, 0, 0, 0, 0, 1);
        body[0] = 'h700; body[1] = 'h702; blen = 2;
        expect_replay("R2 youngest match");

        // R1: flush empties the queue
        do_flush();
        enq('h800, 0, 0, 0, 0, 0, 0, 1);
        enq('h801, 0, 0, 0, 0, 0, 0, 1);
        do_flush();
        #1;
        check(loop_active == 0 && rep_valid == 0, "R1 flush state",
              int'({loop_active, rep_valid}), 0);
        @(negedge clk);
        enq('h802, 1, 'h800, 0, 0, 0, 0, 1);
        expect_reject("R1 stale target after flush");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule